// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose I/O peripheral with one pin per bit of its register word, placed on a simple single-cycle register bus. Software writes output values and pin directions through a small set of registers and reads back sampled pin levels, the output latch and the direction setting. The register word width is a build-time choice of 8, 16, 32 or 64 bits.

Several build-time options pick the register behaviour. The output personality is one of: a single data register that both drives outputs and returns pin levels; a set/clear pair that raises or lowers individual pins; or a set register that alone holds the output latch while the data register only reports inputs. The direction personality is none (all pins always driven, bidirectional by external wiring), an output-enable register, or an input-select register with opposite polarity. Pin numbering can be mirrored and the bytes of the register word swapped, for buses that see the word in big-endian order. An illegal width or a byte swap on a 64-bit word stops elaboration.

Top module: `mmio_gpio`

## Requirements
- R1: After reset every output latch bit is 0; with a direction register present every output enable is 0, and an input-select register reads back all ones.
- R2: In data-only personality a write to the data register (index 0) sets the output latch to the written word, and writes to set (index 1) and clear (index 2) change nothing.
- R3: In set/clear personality a 1 in a set write drives that pin high, a 1 in a clear write drives it low, 0 bits leave pins unchanged, and data register writes change nothing.
- R4: In set-latch personality a write to the set register replaces the whole output latch, reading the set register returns the latch, and reading the data register returns the sampled pin inputs.
- R5: With an output-enable register (index 3), each pin's output enable equals its bit in that register, and the register reads back as written.
- R6: With an input-select register (index 4), each pin's output enable is the inverse of its bit, and the register reads back as written.
- R7: With no direction register, every output enable is 1 at all times and writes to indices 3 and 4 have no effect; both read as 0.
- R8: With mirrored numbering, pin n corresponds to register bit W-1-n for writes and reads alike.
- R9: With byte swap, register byte k corresponds to pin byte NB-1-k, for writes and reads alike.
- R10: Read data appears on the read port after the clock edge that samples the read strobe and holds until the next read; registers absent from the chosen personalities, and the clear register, read as 0.
- R11: A change on a pin input is returned by a data register read issued at the third clock edge after the change, and not by reads at the first or second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register index: 0 data, 1 set, 2 clear, 3 output-enable, 4 input-select |
| bus_wr | input | 1 | Write strobe, acts at the rising edge |
| bus_rd | input | 1 | Read strobe, loads bus_rdata at the rising edge |
| bus_wdata | input | W | Write word |
| bus_rdata | output | W | Registered read word |
| gpio_in | input | W | Pin input levels, asynchronous |
| gpio_out | output | W | Pin output values |
| gpio_oe | output | W | Pin output enables, 1 drives |

## Verification
Assertions watch, every cycle, that set writes raise and clear writes lower the addressed latch bits, that the latch is untouched when no write lands, that a direction write is stored, that the read port holds between strobes, that enables are off just after reset, and that the synchroniser output equals the input two edges earlier. Which personality ignores which register, the polarity seen at the enable pins, the mirrored and byte-swapped mappings and the exact read latency of a pin change can only be shown by the bench's scenarios, which drive four differently configured instances.

// File: rtl/gpio_pkg.sv
// Shared types for the GPIO controller: output and direction personalities
// and the register index map. Assumes a 3-bit register index bus.
package gpio_pkg;

    typedef enum logic [1:0] {
        PERS_DATA     = 2'd0,
        PERS_SETCLR   = 2'd1,
        PERS_SETLATCH = 2'd2
    } pers_e;

    typedef enum logic [1:0] {
        DIR_NONE   = 2'd0,
        DIR_OUTREG = 2'd1,
        DIR_INREG  = 2'd2
    } dir_e;

    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_DATA = 3'd0;
    localparam logic [IDX_W-1:0] IDX_SET  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_CLR  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_DOUT = 3'd3;
    localparam logic [IDX_W-1:0] IDX_DIN  = 3'd4;

endpackage

// File: rtl/gpio_bit_order.sv
// Permutes a register word between bus order and pin order. Mirroring and
// byte swapping commute and are each their own inverse, so the same
// instance serves both directions. Assumes W is a multiple of 8.
module gpio_bit_order #(
    parameter int W         = 32,
    parameter bit BIT_REV   = 1'b0,
    parameter bit BYTE_SWAP = 1'b0
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int R = BIT_REV ? (W - 1 - i) : i;
        localparam int S = BYTE_SWAP ? (8 * (NB - 1 - R / 8) + R % 8) : R;
        // route one bit through the combined permutation
        assign dout[i] = din[S];
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for the pin inputs. Assumes inputs may change at
// any time relative to clk; output lags the input by two edges.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   warm_q;

    // shift the pin levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    // count edges since reset so the delay check starts once both flops are live
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assign dout = stage2_q;

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (dout == $past(din, 2))); // R11

endmodule

// File: rtl/gpio_out_latch.sv
// Output latch with the write semantics of the chosen personality.
// Operands are in pin order; at most one write strobe is high per cycle.
module gpio_out_latch #(
    parameter int             W    = 32,
    parameter gpio_pkg::pers_e PERS = gpio_pkg::PERS_DATA
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wval,
    output logic [W-1:0] latch_q
);
    import gpio_pkg::*;

    // apply the personality's write rule to the latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            case (PERS)
                PERS_DATA: begin
                    if (wr_data) latch_q <= wval;
                end
                PERS_SETCLR: begin
                    if (wr_set)      latch_q <= latch_q | wval;
                    else if (wr_clr) latch_q <= latch_q & ~wval;
                end
                PERS_SETLATCH: begin
                    if (wr_set) latch_q <= wval;
                end
                default: latch_q <= latch_q;
            endcase
        end
    end

    if (PERS == PERS_SETCLR) begin : g_setclr_chk
        AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            wr_set |=> ((latch_q & $past(wval)) == $past(wval))); // R3
        AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
            wr_clr |=> ((latch_q & $past(wval)) == '0)); // R3
    end

    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_data || wr_set || wr_clr) |=> $stable(latch_q)); // R2

endmodule

// File: rtl/gpio_dir_reg.sv
// Direction register and output-enable generation. Polarity depends on the
// direction personality; with none, all enables stay high.
module gpio_dir_reg #(
    parameter int             W        = 32,
    parameter gpio_pkg::dir_e DIR_MODE = gpio_pkg::DIR_OUTREG
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dout,
    input  logic         wr_din,
    input  logic [W-1:0] wval,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] oe
);
    import gpio_pkg::*;

    localparam logic [W-1:0] RST_VAL = (DIR_MODE == DIR_INREG) ? '1 : '0;

    logic wr_own;
    // pick the write strobe that belongs to this personality
    always_comb begin
        case (DIR_MODE)
            DIR_OUTREG: wr_own = wr_dout;
            DIR_INREG:  wr_own = wr_din;
            default:    wr_own = 1'b0;
        endcase
    end

    // hold the stored direction word
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= RST_VAL;
        else if (wr_own) dir_q <= wval;
    end

    // convert the stored word into pin enables
    always_comb begin
        case (DIR_MODE)
            DIR_OUTREG: oe = dir_q;
            DIR_INREG:  oe = ~dir_q;
            default:    oe = '1;
        endcase
    end

    AST_DIR_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_own |=> (dir_q == $past(wval))); // R5 R6

endmodule

// File: rtl/mmio_gpio.sv
// Memory-mapped GPIO controller top: register decode, output latch,
// direction register, input synchroniser and registered readback.
// Assumes single-cycle strobes; bus_rdata is loaded on bus_rd only.
module mmio_gpio #(
    parameter int              W         = 32,
    parameter gpio_pkg::pers_e PERS      = gpio_pkg::PERS_DATA,
    parameter gpio_pkg::dir_e  DIR_MODE  = gpio_pkg::DIR_OUTREG,
    parameter bit              BIT_REV   = 1'b0,
    parameter bit              BYTE_SWAP = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [gpio_pkg::IDX_W-1:0] bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [W-1:0]             bus_wdata,
    output logic [W-1:0]             bus_rdata,
    input  logic [W-1:0]             gpio_in,
    output logic [W-1:0]             gpio_out,
    output logic [W-1:0]             gpio_oe
);
    import gpio_pkg::*;

    if (!(W == 8 || W == 16 || W == 32 || W == 64)) begin : g_bad_width
        $error("mmio_gpio: W must be 8, 16, 32 or 64");
    end
    if (BYTE_SWAP && W == 64) begin : g_bad_swap
        $error("mmio_gpio: byte swap is not available for a 64-bit word");
    end

    logic [W-1:0] wval_pins;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] in_sync;
    logic [W-1:0] rd_pins;
    logic [W-1:0] rd_bus;
    logic         wr_data, wr_set, wr_clr, wr_dout, wr_din;

    // decode the write strobe by register index
    always_comb begin
        wr_data = bus_wr && (bus_addr == IDX_DATA);
        wr_set  = bus_wr && (bus_addr == IDX_SET);
        wr_clr  = bus_wr && (bus_addr == IDX_CLR);
        wr_dout = bus_wr && (bus_addr == IDX_DOUT);
        wr_din  = bus_wr && (bus_addr == IDX_DIN);
    end

    gpio_bit_order #(.W(W), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_wr_order (
        .din  (bus_wdata),
        .dout (wval_pins)
    );

    gpio_out_latch #(.W(W), .PERS(PERS)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (wr_data),
        .wr_set  (wr_set),
        .wr_clr  (wr_clr),
        .wval    (wval_pins),
        .latch_q (latch_q)
    );

    gpio_dir_reg #(.W(W), .DIR_MODE(DIR_MODE)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_dout (wr_dout),
        .wr_din  (wr_din),
        .wval    (wval_pins),
        .dir_q   (dir_q),
        .oe      (gpio_oe)
    );

    gpio_in_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (gpio_in),
        .dout  (in_sync)
    );

    assign gpio_out = latch_q;

    // select the readback word in pin order
    always_comb begin
        rd_pins = '0;
        case (bus_addr)
            IDX_DATA: rd_pins = in_sync;
            IDX_SET:  if (PERS != PERS_DATA)    rd_pins = latch_q;
            IDX_DOUT: if (DIR_MODE == DIR_OUTREG) rd_pins = dir_q;
            IDX_DIN:  if (DIR_MODE == DIR_INREG)  rd_pins = dir_q;
            default:  rd_pins = '0;
        endcase
    end

    gpio_bit_order #(.W(W), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_rd_order (
        .din  (rd_pins),
        .dout (rd_bus)
    );

    // load the read port on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_bus;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R10
    AST_RESET_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ((DIR_MODE != DIR_NONE) && $rose(rst_n)) |-> (gpio_oe == '0)); // R1
    AST_RESET_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gpio_out == '0)); // R1

endmodule

// File: tb/mmio_gpio_test.sv
`timescale 1ns/1ps
// Directed bench: four instances with different personalities share one bus.
module mmio_gpio_test;
    import gpio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [63:0] wd = '0;
    logic [3:0]  wr_sel = '0;
    logic [3:0]  rd_sel = '0;

    logic [31:0] in_a = '0;
    logic [15:0] in_b = '0, in_c = '0, in_d = '0;
    logic [31:0] rd_a, out_a, oe_a;
    logic [15:0] rd_b, out_b, oe_b, rd_c, out_c, oe_c, rd_d, out_d, oe_d;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // data-only, output-enable register, 32 bits
    mmio_gpio #(.W(32), .PERS(PERS_DATA), .DIR_MODE(DIR_OUTREG)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_sel[0]),
        .bus_rd(rd_sel[0]), .bus_wdata(wd[31:0]), .bus_rdata(rd_a),
        .gpio_in(in_a), .gpio_out(out_a), .gpio_oe(oe_a));
    // set/clear, input-select register, 16 bits
    mmio_gpio #(.W(16), .PERS(PERS_SETCLR), .DIR_MODE(DIR_INREG)) uut_sc (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_sel[1]),
        .bus_rd(rd_sel[1]), .bus_wdata(wd[15:0]), .bus_rdata(rd_b),
        .gpio_in(in_b), .gpio_out(out_b), .gpio_oe(oe_b));
    // set-latch, no direction register, mirrored, 16 bits
    mmio_gpio #(.W(16), .PERS(PERS_SETLATCH), .DIR_MODE(DIR_NONE), .BIT_REV(1'b1)) uut_sl (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_sel[2]),
        .bus_rd(rd_sel[2]), .bus_wdata(wd[15:0]), .bus_rdata(rd_c),
        .gpio_in(in_c), .gpio_out(out_c), .gpio_oe(oe_c));
    // data-only, byte swapped, 16 bits
    mmio_gpio #(.W(16), .PERS(PERS_DATA), .DIR_MODE(DIR_OUTREG), .BYTE_SWAP(1'b1)) uut_bs (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr_sel[3]),
        .bus_rd(rd_sel[3]), .bus_wdata(wd[15:0]), .bus_rdata(rd_d),
        .gpio_in(in_d), .gpio_out(out_d), .gpio_oe(oe_d));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // write one register of one instance; returns at the following negedge
    task automatic bus_write(input int sel, input logic [2:0] a, input logic [63:0] v);
        addr = a; wd = v; wr_sel[sel] = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_sel = '0;
    endtask

    // read one register of one instance; returns at the following negedge
    task automatic bus_read(input int sel, input logic [2:0] a, output logic [63:0] v);
        addr = a; rd_sel[sel] = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_sel = '0;
        case (sel)
            0: v = {32'h0, rd_a};
            1: v = {48'h0, rd_b};
            2: v = {48'h0, rd_c};
            default: v = {48'h0, rd_d};
        endcase
    endtask

    task automatic t_reset;
        logic [63:0] v;
        chk("R1 out after reset (data-only)", out_a, 0);
        chk("R1 oe after reset (output-enable reg)", oe_a, 0);
        chk("R1 out after reset (set/clear)", out_b, 0);
        chk("R1 oe after reset (input-select reg)", oe_b, 0);
        bus_read(1, IDX_DIN, v);
        chk("R1 input-select reads all ones", v, 64'hFFFF);
        chk("R7 oe high with no direction reg", oe_c, 64'hFFFF);
    endtask

    task automatic t_data_only;
        logic [63:0] v;
        bus_write(0, IDX_DATA, 64'hDEADBEEF);
        chk("R2 data write drives outputs", out_a, 64'hDEADBEEF);
        bus_write(0, IDX_SET, 64'h0000FFFF);
        chk("R2 set write ignored", out_a, 64'hDEADBEEF);
        bus_write(0, IDX_CLR, 64'hFFFFFFFF);
        chk("R2 clear write ignored", out_a, 64'hDEADBEEF);
        bus_read(0, IDX_SET, v);
        chk("R10 absent set reg reads zero", v, 0);
        bus_read(0, IDX_DIN, v);
        chk("R10 absent input-select reads zero", v, 0);
    endtask

    task automatic t_dir_out;
        logic [63:0] v;
        bus_write(0, IDX_DOUT, 64'h0000FFFF);
        chk("R5 oe follows output-enable reg", oe_a, 64'h0000FFFF);
        bus_read(0, IDX_DOUT, v);
        chk("R5 output-enable reg readback", v, 64'h0000FFFF);
        bus_write(0, IDX_DIN, 64'hFFFFFFFF);
        chk("R5 input-select write ignored when absent", oe_a, 64'h0000FFFF);
    endtask

    task automatic t_sync_latency;
        logic [63:0] v;
        in_a = 32'hA5A5_0F0F;
        bus_read(0, IDX_DATA, v);
        chk("R11 read at first edge returns old", v, 0);
        bus_read(0, IDX_DATA, v);
        chk("R11 read at second edge returns old", v, 0);
        bus_read(0, IDX_DATA, v);
        chk("R11 read at third edge returns new", v, 64'hA5A5_0F0F);
        chk("R10 rdata held between reads", rd_a, 32'hA5A5_0F0F);
    endtask

    task automatic t_set_clear;
        logic [63:0] v;
        bus_write(1, IDX_SET, 64'h00FF);
        chk("R3 set raises pins", out_b, 64'h00FF);
        bus_write(1, IDX_CLR, 64'h000F);
        chk("R3 clear lowers pins", out_b, 64'h00F0);
        bus_write(1, IDX_SET, 64'h0000);
        chk("R3 zero set bits leave pins", out_b, 64'h00F0);
        bus_write(1, IDX_CLR, 64'h0000);
        chk("R3 zero clear bits leave pins", out_b, 64'h00F0);
        bus_write(1, IDX_DATA, 64'hFFFF);
        chk("R3 data write ignored", out_b, 64'h00F0);
        bus_read(1, IDX_CLR, v);
        chk("R10 clear reg reads zero", v, 0);
        bus_write(1, IDX_DIN, 64'h00F0);
        chk("R6 oe inverted from input-select", oe_b, 64'hFF0F);
        bus_read(1, IDX_DIN, v);
        chk("R6 input-select readback", v, 64'h00F0);
        bus_read(1, IDX_DOUT, v);
        chk("R10 absent output-enable reads zero", v, 0);
    endtask

    task automatic t_set_latch_rev;
        logic [63:0] v;
        bus_write(2, IDX_SET, 64'h0001);
        chk("R8 mirrored set bit 0 drives pin 15", out_c, 64'h8000);
        bus_write(2, IDX_SET, 64'h0030);
        chk("R4 set write replaces latch", out_c, 64'h0C00);
        bus_read(2, IDX_SET, v);
        chk("R4 set reg reads latch", v, 64'h0030);
        in_c = 16'h0003;
        repeat (3) @(negedge clk);
        bus_read(2, IDX_DATA, v);
        chk("R4 R8 data reads mirrored inputs", v, 64'hC000);
        bus_write(2, IDX_DOUT, 64'h1234);
        chk("R7 direction write ignored", oe_c, 64'hFFFF);
        bus_read(2, IDX_DOUT, v);
        chk("R7 output-enable reads zero", v, 0);
        bus_read(2, IDX_DIN, v);
        chk("R7 input-select reads zero", v, 0);
    endtask

    task automatic t_byte_swap;
        logic [63:0] v;
        bus_write(3, IDX_DATA, 64'h1234);
        chk("R9 byte swap on write", out_d, 64'h3412);
        in_d = 16'hABCD;
        repeat (3) @(negedge clk);
        bus_read(3, IDX_DATA, v);
        chk("R9 byte swap on read", v, 64'hCDAB);
        bus_write(3, IDX_DOUT, 64'h00FF);
        chk("R9 byte swap on direction", oe_d, 64'hFF00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_only();
        t_dir_out();
        t_sync_latency();
        t_set_clear();
        t_set_latch_rev();
        t_byte_swap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule